// File: doc/BRIEF.md
# Dual-Channel Dark Offset Corrector

This block sits between a two-output line sensor and the pixel pipeline. Each sensor output delivers a 16-bit sample, and the two outputs carry different dark levels. The block learns one dark level per output while the sensor is kept dark, then subtracts that level from every later sample of the same output. This lets the two halves of a line share one black point without any analog trim.

Samples arrive as pairs: one from output A and one from output B, accepted together through a valid/ready handshake. After reset, or after a one-cycle restart pulse, the first 2^AVG_LOG2 accepted pairs are averaged per output. The block then raises a done flag and freezes the two levels. Until the flag is set, samples pass through unchanged. Each corrected pair leaves as two pixels on one valid/ready stream, output A first.

Top module: `dkc_top`

## Requirements
- R1: After synchronous reset, `cal_done` and `out_valid` are 0 and `in_ready` is 1.
- R2: A pair is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while the output holds a channel-A pixel. It is also 0 while the output holds a channel-B pixel that `out_ready` does not take.
- R3: Each taken pair appears on the output as two pixels. The channel-A pixel comes first with `out_chan` = 0, starting the cycle after the pair is taken. The channel-B pixel follows with `out_chan` = 1 on the cycle after channel A is taken.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_chan` hold their values.
- R5: Calibration averages the first 2^AVG_LOG2 pairs taken after reset or restart. Each output's level is the sum of its samples shifted right by AVG_LOG2, truncating. `cal_done` rises on the cycle after the last of these pairs is taken.
- R6: While `cal_done` is 0, every taken sample is output unchanged. This includes the pair that completes calibration.
- R7: While `cal_done` is 1, each sample is output as the sample minus its own output's level. When the sample is below the level, the result is 0 rather than a wrapped value.
- R8: While `cal_done` is 1 and no restart is given, the stored levels do not change. The same input always yields the same corrected pixel.
- R9: A 1 on `recal` at a clock edge clears `cal_done` on the next cycle and restarts the sample count from zero. A pair taken at that same edge is corrected with the state before the edge and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| recal | input | 1 | One-cycle pulse that restarts dark-level measurement |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | 16 | Sample from sensor output A |
| in_b | input | 16 | Sample from sensor output B |
| out_valid | output | 1 | Pixel present |
| out_ready | input | 1 | Downstream takes the pixel |
| out_data | output | 16 | Corrected pixel |
| out_chan | output | 1 | Source of pixel: 0 = A, 1 = B |
| cal_done | output | 1 | Both dark levels are stored |

## Verification
A pair taken at clock edge k gives its channel-A pixel on the cycle after k. Its channel-B pixel is due one cycle after channel A is taken, and `cal_done` is due one cycle after the completing pair. The stimulus task records the expected pixels at the edge where the handshake completes. A monitor then compares each pixel only at the edge where `out_valid` and `out_ready` are both high, so stalls never shift the comparison. The done flag is read half a cycle after the edge where it is due, both after the last calibration pair and after a restart.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    // Floor-at-zero difference used for dark removal.
    function automatic logic [15:0] sat_sub16(input logic [15:0] x, input logic [15:0] y);
        return (x > y) ? (x - y) : 16'd0;
    endfunction

endpackage

// File: rtl/dkc_offset_cal.sv
module dkc_offset_cal #(
    parameter int SAMPLE_W = 16,
    parameter int AVG_LOG2 = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] level,
    output logic                done
);
    localparam int ACC_W = SAMPLE_W + AVG_LOG2;

    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    acc_sum;
    logic [AVG_LOG2-1:0] cnt_q;
    logic                last_sample;

    always_comb begin
        acc_sum     = acc_q + ACC_W'(sample);
        last_sample = &cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q <= '0;
            cnt_q <= '0;
            level <= '0;
            done  <= 1'b0;
        end else if (take && !done) begin
            if (last_sample) begin
                level <= SAMPLE_W'(acc_sum >> AVG_LOG2);
                done  <= 1'b1;
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= acc_sum;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8: stored level frozen once measured
    a_r8_level_frozen: assert property (@(posedge clk) disable iff (rst)
        (done && !restart) |=> ($stable(level) && done));

    // R9: restart drops the done flag
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> !done);

endmodule

// File: rtl/dkc_pair_serializer.sv
module dkc_pair_serializer
    import dkc_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] pix_a,
    input  logic [SAMPLE_W-1:0] pix_b,
    output logic                can_load,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output chan_e               out_chan
);
    logic [SAMPLE_W-1:0] held_b;

    assign can_load = !out_valid || (out_chan == CH_B && out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_chan  <= CH_A;
            held_b    <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= pix_a;
            out_chan  <= CH_A;
            held_b    <= pix_b;
        end else if (out_valid && out_ready) begin
            if (out_chan == CH_A) begin
                out_data <= held_b;
                out_chan <= CH_B;
            end else begin
                out_valid <= 1'b0;
            end
        end
    end

    // R4: output held under backpressure
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

    // R3: channel B follows channel A
    a_r3_b_after_a: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_chan == CH_A) |=> (out_valid && out_chan == CH_B));

endmodule

// File: rtl/dkc_top.sv
module dkc_top
    import dkc_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int AVG_LOG2 = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                recal,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_a,
    input  logic [SAMPLE_W-1:0] in_b,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_chan,
    output logic                cal_done
);
    logic                accept;
    logic [SAMPLE_W-1:0] raw_s   [NUM_CH];
    logic [SAMPLE_W-1:0] level_s [NUM_CH];
    logic [SAMPLE_W-1:0] corr_s  [NUM_CH];
    logic [NUM_CH-1:0]   done_s;
    chan_e               chan_s;

    assign accept   = in_valid && in_ready;
    assign raw_s[0] = in_a;
    assign raw_s[1] = in_b;
    assign cal_done = &done_s;
    assign out_chan = chan_s;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dkc_offset_cal #(
            .SAMPLE_W (SAMPLE_W),
            .AVG_LOG2 (AVG_LOG2)
        ) cal_i (
            .clk     (clk),
            .rst     (rst),
            .restart (recal),
            .take    (accept),
            .sample  (raw_s[c]),
            .level   (level_s[c]),
            .done    (done_s[c])
        );

        assign corr_s[c] = cal_done ? sat_sub16(raw_s[c], level_s[c]) : raw_s[c];
    end

    dkc_pair_serializer #(
        .SAMPLE_W (SAMPLE_W)
    ) ser_i (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .pix_a     (corr_s[0]),
        .pix_b     (corr_s[1]),
        .can_load  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_chan  (chan_s)
    );

    // R2: a taken pair shows channel A next cycle
    a_r2_take_to_a: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && out_chan == 1'b0));

    // R6: uncorrected pass-through before calibration
    a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
        (accept && !cal_done) |=> (out_data == $past(in_a)));

    // R7: correction never raises a sample
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (accept && cal_done) |=> (out_data <= $past(in_a)));

endmodule

// File: tb/dkc_top_tb_top.sv
module dkc_top_tb_top;
    localparam int W  = 16;
    localparam int NL = 6;
    localparam int NAVG = 1 << NL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic recal = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [W-1:0] out_data;
    logic out_chan;
    logic cal_done;

    always #5 clk = ~clk;

    dkc_top #(.SAMPLE_W(W), .AVG_LOG2(NL)) dut_i (
        .clk(clk), .rst(rst), .recal(recal),
        .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_chan(out_chan), .cal_done(cal_done)
    );

    typedef struct packed {
        logic [W-1:0] data;
        logic         chan;
        logic [7:0]   req;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // bench model of calibration
    bit          m_done = 0;
    int          m_cnt = 0;
    longint      m_sum_a = 0, m_sum_b = 0;
    logic [W-1:0] m_lvl_a = '0, m_lvl_b = '0;
    int          bp_mode = 0;
    int          cyc = 0;

    function automatic logic [W-1:0] floor_sub(logic [W-1:0] x, logic [W-1:0] y);
        return (x > y) ? W'(x - y) : '0;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Drive one pair; optionally assert recal on the accepting edge.
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input bit rc, input int req);
        exp_t ea, eb;
        int rq;
        @(negedge clk); #1;
        in_valid = 1'b1; in_a = a; in_b = b; recal = rc;
        while (!in_ready) begin @(negedge clk); #1; end
        rq = req;
        if (m_done) rq = (req == 0) ? 7 : req;
        else        rq = (req == 0) ? 6 : req;
        ea.data = m_done ? floor_sub(a, m_lvl_a) : a;
        eb.data = m_done ? floor_sub(b, m_lvl_b) : b;
        ea.chan = 1'b0; eb.chan = 1'b1;
        ea.req = 8'(rq); eb.req = 8'(rq);
        exp_q.push_back(ea);
        exp_q.push_back(eb);
        if (rc) begin
            m_done = 0; m_cnt = 0; m_sum_a = 0; m_sum_b = 0;
        end else if (!m_done) begin
            m_sum_a += a; m_sum_b += b; m_cnt++;
            if (m_cnt == NAVG) begin
                m_lvl_a = W'(m_sum_a >> NL);
                m_lvl_b = W'(m_sum_b >> NL);
                m_done = 1; m_cnt = 0; m_sum_a = 0; m_sum_b = 0;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0; recal = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // backpressure pattern, changed well after the edge
    always @(posedge clk) begin
        cyc++;
        #2;
        out_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // monitor / scoreboard
    logic         held_v = 1'b0;
    logic [W-1:0] held_d;
    logic         held_c;
    always @(negedge clk) begin
        if (!rst) begin
            if (held_v && out_valid) begin
                // R4: stalled pixel must not change
                check(out_data == held_d && out_chan == held_c, "R4", out_data, held_d);
            end
            held_v = out_valid && !out_ready;
            held_d = out_data;
            held_c = out_chan;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", out_data, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    // R3: order and source tag
                    check(out_chan == e.chan, "R3", out_chan, e.chan);
                    check(out_data == e.data, $sformatf("R%0d", e.req), out_data, e.data);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(cal_done == 1'b0, "R1", cal_done, 0);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);

        // R5/R6: calibration with distinct per-channel dark levels
        for (int i = 0; i < NAVG; i++) begin
            send(W'(1000 + (i % 8)), W'(2000 + (i % 5) * 3), 0, 6);
            if (i == NAVG - 2) begin
                @(negedge clk);
                check(cal_done == 1'b0, "R5", cal_done, 0);
            end
        end
        @(negedge clk);
        check(cal_done == 1'b1, "R5", cal_done, 1);
        drain();

        // R7: correction and floor at zero
        send(W'(m_lvl_a + 50), W'(m_lvl_b + 7), 0, 7);
        send(m_lvl_a, m_lvl_b, 0, 7);
        send(16'd0, W'(m_lvl_b - 1), 0, 7);
        send(16'hFFFF, 16'd5, 0, 7);
        drain();

        // R2/R3/R4: backpressure, back-to-back pairs
        bp_mode = 1;
        for (int i = 0; i < 24; i++) send(W'(900 + i * 40), W'(2100 - i * 20), 0, 2);
        drain();
        bp_mode = 0;

        // R8: same input repeats to same output
        for (int i = 0; i < 4; i++) send(16'd1500, 16'd2500, 0, 8);
        drain();

        // R9: recal with a pair on the same edge uses old levels
        send(16'd1300, 16'd2300, 1, 9);
        @(negedge clk);
        check(cal_done == 1'b0, "R9", cal_done, 0);
        drain();

        // new darker level, passthrough while measuring (R6), then R5 again
        for (int i = 0; i < NAVG; i++) send(W'(300 + (i % 4)), W'(700 + (i % 6)), 0, 6);
        @(negedge clk);
        check(cal_done == 1'b1, "R5", cal_done, 1);
        drain();
        send(16'd400, 16'd650, 0, 7);
        send(16'd1000, 16'd1000, 0, 7);
        drain();

        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        summary();
    end

endmodule